// File: doc/BRIEF.md
# Pipeline Stall Cycle Accountant

This block keeps the cycle budget of a small in-order pipeline that issues instructions one at a time or as parallel groups. Each clock at most one instruction description arrives on a valid-qualified input. The description gives up to two source register numbers, each with its own use flag. It also gives the destination of a load, whether the instruction is a control transfer and whether that transfer was taken, a base cycle count, and two markers that say where the instruction sits in its group. The block does not model what the instructions compute. It only charges their cost.

Load-use hazards are found with a per-register scoreboard. Loads in the current group set bits in a pending mask. That mask becomes the hazard mask for later instructions only when the group closes. Any source that hits the hazard mask costs a fixed stall penalty. A taken transfer costs a fixed branch penalty. Members of a group overlap in time, so the group is charged once, at its closing member, with the cost of its most expensive member. Load-stall and branch-stall cycles and the taken and untaken transfers are also counted on their own. All five counters saturate.

Top module: `stall_cycle_acct`

## Requirements
- R1: A valid load sets the bit of its destination register in the pending mask. A source read by a later member of the same group sees no hazard from that load.
- R2: When a group closes (last marker set), the hazard mask is replaced by the pending mask, not merged with it. Loads from groups before the previous one no longer cause stalls.
- R3: Each used source register whose bit is set in the hazard mask adds 2 cycles to the instruction's load stall. Two used sources naming the same hit register add 4.
- R4: A source whose use flag is low never adds stall cycles, whatever register number it carries.
- R5: A taken control transfer adds 2 branch-stall cycles and increments the taken counter by 1. A not-taken transfer increments the untaken counter and adds no stall. A non-transfer instruction changes neither counter.
- R6: An instruction's cost is its base cycles plus its load-stall and branch-stall cycles.
- R7: Total cycles change only at a group's closing member, and then by the largest cost of any member of that group. first=1,last=1 is a single instruction; first=1,last=0 opens a group; first=0,last=1 closes it; first=0,last=0 is a middle member.
- R8: An opening member (first set) discards the pending mask and the running maximum left by any earlier group that never closed.
- R9: The load-stall and branch-stall totals accumulate every instruction's stalls, independently of the total cycle count.
- R10: Every counter stops at its all-ones value instead of wrapping.
- R11: A synchronous reset clears all counters, the pending mask, the hazard mask and the running maximum.
- R12: A cycle with valid low changes no counter and no mask, whatever the other inputs carry.
- R13: The effect of an accepted instruction is visible on the outputs after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Instruction description present this cycle |
| src_a_i | input | REG_W (4) | First source register number |
| src_a_en_i | input | 1 | First source is read |
| src_b_i | input | REG_W (4) | Second source register number |
| src_b_en_i | input | 1 | Second source is read |
| ld_i | input | 1 | Instruction is a load |
| ld_dst_i | input | REG_W (4) | Load destination register |
| cti_i | input | 1 | Instruction is a control transfer |
| taken_i | input | 1 | Control transfer was taken |
| base_cyc_i | input | BASE_W (8) | Base cycle count of the instruction |
| first_i | input | 1 | Instruction opens a group |
| last_i | input | 1 | Instruction closes a group |
| total_cyc_o | output | CNT_W (32) | Accumulated total cycles |
| ld_stall_o | output | CNT_W (32) | Accumulated load-stall cycles |
| br_stall_o | output | CNT_W (32) | Accumulated branch-stall cycles |
| taken_cnt_o | output | CNT_W (32) | Taken control transfers |
| untaken_cnt_o | output | CNT_W (32) | Not-taken control transfers |

## Verification
The bench runs in a small configuration (12-bit counters, 4-bit base counts). Every pairing of load destination and later source register is swept. This separates a correct register decode from an off-by-one bit or a wrong source port, and disabled sources that carry the loaded register number show whether the use flags gate the hit. Every pair of base costs in two-member groups, plus three-member groups with a middle member, shows the maximum-not-sum charge and the single commit at the closing member. Other patterns cover unclosed groups, idle cycles carrying junk, a reset in mid-run and a long taken-transfer stream that drives each counter into saturation.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

    localparam int unsigned LOAD_PENALTY   = 2;
    localparam int unsigned BRANCH_PENALTY = 2;

    // Position of an instruction within its issue group, coded {last, first}
    typedef enum logic [1:0] {
        GP_MID  = 2'b00,
        GP_HEAD = 2'b01,
        GP_TAIL = 2'b10,
        GP_SOLO = 2'b11
    } grp_pos_e;

    function automatic grp_pos_e grp_pos(input logic first, input logic last);
        return grp_pos_e'({last, first});
    endfunction

    function automatic logic grp_opens(input grp_pos_e p);
        return (p == GP_HEAD) || (p == GP_SOLO);
    endfunction

    function automatic logic grp_closes(input grp_pos_e p);
        return (p == GP_TAIL) || (p == GP_SOLO);
    endfunction

endpackage

// File: rtl/acct_scoreboard.sv
module acct_scoreboard
    import stall_acct_pkg::*;
#(
    parameter int unsigned NREG = 16,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             vld_i,
    input  grp_pos_e         pos_i,
    input  logic [REG_W-1:0] src_a_i,
    input  logic             src_a_en_i,
    input  logic [REG_W-1:0] src_b_i,
    input  logic             src_b_en_i,
    input  logic             ld_i,
    input  logic [REG_W-1:0] ld_dst_i,
    output logic [1:0]       hits_o
);

    typedef struct packed {
        logic [NREG-1:0] pend;
        logic [NREG-1:0] act;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [NREG-1:0] carry_pend;
    logic [NREG-1:0] ld_mask;
    logic            hit_a, hit_b;

    always_comb begin
        st_d       = st_q;
        carry_pend = grp_opens(pos_i) ? '0 : st_q.pend;
        ld_mask    = '0;
        if (ld_i) begin
            ld_mask[ld_dst_i] = 1'b1;
        end
        if (vld_i) begin
            st_d.pend = carry_pend | ld_mask;
            if (grp_closes(pos_i)) begin
                st_d.act = carry_pend | ld_mask;
            end
        end
        hit_a  = src_a_en_i && st_q.act[src_a_i];
        hit_b  = src_b_en_i && st_q.act[src_b_i];
        hits_o = {1'b0, hit_a} + {1'b0, hit_b};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: hazard mask moves only when a group closes
    a_r2_act_only_at_close: assert property (@(posedge clk_i) disable iff (rst_i)
        !(vld_i && grp_closes(pos_i)) |=> $stable(st_q.act));

    // R1: a load leaves its destination marked as pending
    a_r1_pend_marked: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && ld_i) |=> st_q.pend[$past(ld_dst_i)]);

    // R11: reset empties both masks
    a_r11_masks_clear: assert property (@(posedge clk_i)
        rst_i |=> (st_q.pend == '0) && (st_q.act == '0));

endmodule

// File: rtl/acct_group_max.sv
module acct_group_max
    import stall_acct_pkg::*;
#(
    parameter int unsigned COST_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  grp_pos_e          pos_i,
    input  logic [COST_W-1:0] cost_i,
    output logic              commit_o,
    output logic [COST_W-1:0] commit_amt_o
);

    typedef struct packed {
        logic [COST_W-1:0] peak;
    } gm_state_t;

    gm_state_t st_d, st_q;

    logic [COST_W-1:0] run_peak;
    logic [COST_W-1:0] new_peak;

    always_comb begin
        st_d     = st_q;
        run_peak = grp_opens(pos_i) ? '0 : st_q.peak;
        new_peak = (cost_i > run_peak) ? cost_i : run_peak;
        if (vld_i) begin
            st_d.peak = grp_closes(pos_i) ? '0 : new_peak;
        end
        commit_o     = vld_i && grp_closes(pos_i);
        commit_amt_o = new_peak;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the running peak of an open group never falls below a member's cost
    a_r7_peak_covers_member: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && !grp_closes(pos_i)) |=> (st_q.peak >= $past(cost_i)));

    // R12: idle cycles leave the running peak alone
    a_r12_peak_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> $stable(st_q.peak));

endmodule

// File: rtl/acct_sat_ctr.sv
module acct_sat_ctr #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 11,
    localparam int unsigned SUM_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + SUM_W'(inc_i);
        if (inc_en_i) begin
            st_d.cnt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a counter never moves backwards
    a_r10_no_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (st_q.cnt >= $past(st_q.cnt)));

    // R10: a full counter stays full
    a_r10_sat_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.cnt == '1) |=> (st_q.cnt == '1));

    // R11: reset clears the count
    a_r11_ctr_clear: assert property (@(posedge clk_i)
        rst_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/stall_cycle_acct.sv
module stall_cycle_acct
    import stall_acct_pkg::*;
#(
    parameter int unsigned NREG   = 16,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned BASE_W = 8,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  logic [REG_W-1:0]  src_a_i,
    input  logic              src_a_en_i,
    input  logic [REG_W-1:0]  src_b_i,
    input  logic              src_b_en_i,
    input  logic              ld_i,
    input  logic [REG_W-1:0]  ld_dst_i,
    input  logic              cti_i,
    input  logic              taken_i,
    input  logic [BASE_W-1:0] base_cyc_i,
    input  logic              first_i,
    input  logic              last_i,
    output logic [CNT_W-1:0]  total_cyc_o,
    output logic [CNT_W-1:0]  ld_stall_o,
    output logic [CNT_W-1:0]  br_stall_o,
    output logic [CNT_W-1:0]  taken_cnt_o,
    output logic [CNT_W-1:0]  untaken_cnt_o
);

    localparam int unsigned COST_W    = BASE_W + 3;
    localparam int unsigned NCTR      = 5;
    localparam int unsigned C_TOTAL   = 0;
    localparam int unsigned C_LDST    = 1;
    localparam int unsigned C_BRST    = 2;
    localparam int unsigned C_TAKEN   = 3;
    localparam int unsigned C_UNTAKEN = 4;

    grp_pos_e          pos;
    logic [1:0]        hits;
    logic [COST_W-1:0] ld_stall;
    logic [COST_W-1:0] br_stall;
    logic [COST_W-1:0] cost;
    logic              br_taken;
    logic              br_untaken;
    logic              commit;
    logic [COST_W-1:0] commit_amt;

    logic              inc_en  [NCTR];
    logic [COST_W-1:0] inc_val [NCTR];
    logic [CNT_W-1:0]  cnt     [NCTR];

    always_comb begin
        pos        = grp_pos(first_i, last_i);
        br_taken   = vld_i && cti_i && taken_i;
        br_untaken = vld_i && cti_i && !taken_i;
        ld_stall   = COST_W'(hits) * COST_W'(LOAD_PENALTY);
        br_stall   = br_taken ? COST_W'(BRANCH_PENALTY) : '0;
        cost       = COST_W'(base_cyc_i) + ld_stall + br_stall;

        inc_en[C_TOTAL]    = commit;
        inc_val[C_TOTAL]   = commit_amt;
        inc_en[C_LDST]     = vld_i;
        inc_val[C_LDST]    = ld_stall;
        inc_en[C_BRST]     = br_taken;
        inc_val[C_BRST]    = br_stall;
        inc_en[C_TAKEN]    = br_taken;
        inc_val[C_TAKEN]   = COST_W'(1);
        inc_en[C_UNTAKEN]  = br_untaken;
        inc_val[C_UNTAKEN] = COST_W'(1);
    end

    acct_scoreboard #(
        .NREG (NREG)
    ) u_scoreboard (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vld_i      (vld_i),
        .pos_i      (pos),
        .src_a_i    (src_a_i),
        .src_a_en_i (src_a_en_i),
        .src_b_i    (src_b_i),
        .src_b_en_i (src_b_en_i),
        .ld_i       (ld_i),
        .ld_dst_i   (ld_dst_i),
        .hits_o     (hits)
    );

    acct_group_max #(
        .COST_W (COST_W)
    ) u_group_max (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .vld_i        (vld_i),
        .pos_i        (pos),
        .cost_i       (cost),
        .commit_o     (commit),
        .commit_amt_o (commit_amt)
    );

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        acct_sat_ctr #(
            .CNT_W (CNT_W),
            .INC_W (COST_W)
        ) u_ctr (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .inc_en_i (inc_en[g]),
            .inc_i    (inc_val[g]),
            .cnt_o    (cnt[g])
        );
    end

    assign total_cyc_o   = cnt[C_TOTAL];
    assign ld_stall_o    = cnt[C_LDST];
    assign br_stall_o    = cnt[C_BRST];
    assign taken_cnt_o   = cnt[C_TAKEN];
    assign untaken_cnt_o = cnt[C_UNTAKEN];

    // R7: non-closing members leave the total untouched
    a_r7_no_commit_midgroup: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && !last_i) |=> $stable(total_cyc_o));

    // R5: a taken transfer bumps the taken count by exactly one until full
    a_r5_taken_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && cti_i && taken_i && (taken_cnt_o != '1))
            |=> (taken_cnt_o == $past(taken_cnt_o) + 1'b1));

    // R5: a non-transfer leaves both transfer counts alone
    a_r5_plain_no_count: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && !cti_i) |=> ($stable(taken_cnt_o) && $stable(untaken_cnt_o)
                               && $stable(br_stall_o)));

    // R12: idle cycles change no output
    a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> ($stable(total_cyc_o) && $stable(ld_stall_o) && $stable(br_stall_o)
                    && $stable(taken_cnt_o) && $stable(untaken_cnt_o)));

    // R3: the load stall of one instruction is at most two penalties
    a_r3_stall_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |-> (ld_stall <= COST_W'(2 * LOAD_PENALTY)));

endmodule

// File: tb/stall_cycle_acct_tb_top.sv
module stall_cycle_acct_tb_top;

    localparam int unsigned NREG   = 16;
    localparam int unsigned CNT_W  = 12;
    localparam int unsigned BASE_W = 4;
    localparam longint      CMAX   = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vld = 1'b0;
    logic [3:0]        sa = '0, sb = '0, dst = '0;
    logic              sae = 1'b0, sbe = 1'b0, ld = 1'b0, cti = 1'b0, tk = 1'b0;
    logic [BASE_W-1:0] base = '0;
    logic              first = 1'b0, last = 1'b0;
    logic [CNT_W-1:0]  total_o, ldst_o, brst_o, tkc_o, utkc_o;

    int errors = 0;
    int checks = 0;
    string req = "R11";

    // independent reference state
    logic [15:0] m_pend = '0, m_act = '0;
    longint m_max = 0, m_total = 0, m_ldst = 0, m_brst = 0, m_tk = 0, m_utk = 0;

    always #2 clk = ~clk;

    stall_cycle_acct #(
        .NREG (NREG), .CNT_W (CNT_W), .BASE_W (BASE_W)
    ) dut_i (
        .clk_i (clk), .rst_i (rst), .vld_i (vld),
        .src_a_i (sa), .src_a_en_i (sae), .src_b_i (sb), .src_b_en_i (sbe),
        .ld_i (ld), .ld_dst_i (dst), .cti_i (cti), .taken_i (tk),
        .base_cyc_i (base), .first_i (first), .last_i (last),
        .total_cyc_o (total_o), .ld_stall_o (ldst_o), .br_stall_o (brst_o),
        .taken_cnt_o (tkc_o), .untaken_cnt_o (utkc_o)
    );

    function automatic longint sat(input longint v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("total", longint'(total_o), m_total);
        chk("load_stall", longint'(ldst_o), m_ldst);
        chk("branch_stall", longint'(brst_o), m_brst);
        chk("taken", longint'(tkc_o), m_tk);
        chk("untaken", longint'(utkc_o), m_utk);
    endtask

    task automatic model_reset();
        m_pend = '0; m_act = '0; m_max = 0;
        m_total = 0; m_ldst = 0; m_brst = 0; m_tk = 0; m_utk = 0;
    endtask

    // Called at a falling edge; result is compared at the next falling edge (R13)
    task automatic issue(input logic v, input logic [3:0] a, input logic ae,
                         input logic [3:0] b, input logic be,
                         input logic l, input logic [3:0] d,
                         input logic c, input logic t, input int bc,
                         input logic f, input logic la);
        longint hits, lst, bst, cost, big;
        vld = v; sa = a; sae = ae; sb = b; sbe = be; ld = l; dst = d;
        cti = c; tk = t; base = BASE_W'(bc); first = f; last = la;
        if (v) begin
            if (f) begin m_pend = '0; m_max = 0; end
            hits = 0;
            if (ae && m_act[a]) hits++;
            if (be && m_act[b]) hits++;
            lst  = 2 * hits;
            bst  = (c && t) ? 2 : 0;
            cost = bc + lst + bst;
            if (l) m_pend[d] = 1'b1;
            big  = (cost > m_max) ? cost : m_max;
            if (la) begin
                m_total = sat(m_total + big);
                m_act   = m_pend;
                m_max   = 0;
            end else begin
                m_max = big;
            end
            m_ldst = sat(m_ldst + lst);
            m_brst = sat(m_brst + bst);
            if (c && t)  m_tk  = sat(m_tk + 1);
            if (c && !t) m_utk = sat(m_utk + 1);
        end
        @(posedge clk);
        #1 vld = 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic solo(input logic [3:0] a, input logic ae, input logic [3:0] b,
                        input logic be, input logic l, input logic [3:0] d, input int bc);
        issue(1'b1, a, ae, b, be, l, d, 1'b0, 1'b0, bc, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        req = "R11";
        model_reset();
        compare_all();

        // R3 and R4: every load destination against every source register;
        // the disabled second source always names the loaded register
        req = "R3";
        for (int d = 0; d < 16; d++) begin
            for (int s = 0; s < 16; s++) begin
                solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(d), 1);
                solo(4'(s), 1'b1, 4'(d), 1'b0, 1'b0, 4'(0), 2);
            end
        end
        // R3: both sources hit the same register
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(6), 1);
        solo(4'(6), 1'b1, 4'(6), 1'b1, 1'b0, 4'(0), 3);
        // R4: both sources disabled, both naming a hit register
        req = "R4";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(9), 1);
        solo(4'(9), 1'b0, 4'(9), 1'b0, 1'b0, 4'(0), 3);

        // R2: hazard mask replaced, not merged
        req = "R2";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(3), 1);
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(7), 1);
        solo(4'(3), 1'b1, 4'(7), 1'b1, 1'b0, 4'(0), 1);

        // R1: load invisible inside its own group, visible after
        req = "R1";
        issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(5), 1'b0, 1'b0, 1, 1'b1, 1'b0);
        issue(1'b1, 4'(5), 1'b1, 4'(0), 1'b0, 1'b0, 4'(0), 1'b0, 1'b0, 1, 1'b0, 1'b1);
        solo(4'(5), 1'b1, 4'(0), 1'b0, 1'b0, 4'(0), 1);

        // R6 and R7: every pair of base costs in two-member groups,
        // with a taken transfer on the first member for odd pairs
        req = "R7";
        for (int b1 = 0; b1 < 16; b1++) begin
            for (int b2 = 0; b2 < 16; b2++) begin
                issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0),
                      1'b1, 1'((b1 + b2) % 2), b1, 1'b1, 1'b0);
                issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0),
                      1'b0, 1'b0, b2, 1'b0, 1'b1);
            end
        end
        // R7: three-member groups with a middle member holding the maximum
        for (int m = 0; m < 16; m++) begin
            issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1'b0, 1'b0, 3, 1'b1, 1'b0);
            issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1'b0, 1'b0, m, 1'b0, 1'b0);
            issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1'b0, 1'b0, 5, 1'b0, 1'b1);
        end
        // R6: cost includes load stall; stalled member wins the maximum
        req = "R6";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(11), 1);
        issue(1'b1, 4'(11), 1'b1, 4'(11), 1'b1, 1'b0, 4'(0), 1'b1, 1'b1, 8, 1'b1, 1'b0);
        issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1'b0, 1'b0, 12, 1'b0, 1'b1);

        // R8: an unclosed group is discarded by the next opening member
        req = "R8";
        issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(13), 1'b0, 1'b0, 15, 1'b1, 1'b0);
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1);
        solo(4'(13), 1'b1, 4'(0), 1'b0, 1'b0, 4'(0), 1);

        // R5 and R9: transfer kinds
        req = "R5";
        for (int k = 0; k < 4; k++) begin
            issue(1'b1, 4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0),
                  1'(k / 2), 1'(k % 2), k, 1'b1, 1'b1);
        end
        req = "R9";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(2), 0);
        issue(1'b1, 4'(2), 1'b1, 4'(0), 1'b0, 1'b0, 4'(0), 1'b1, 1'b1, 0, 1'b1, 1'b0);

        // R12: idle cycles carrying junk, then observe the hazard mask
        req = "R12";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b0, 4'(0), 1);
        for (int j = 0; j < 4; j++) begin
            issue(1'b0, 4'(2), 1'b1, 4'(2), 1'b1, 1'b1, 4'(2), 1'b1, 1'b1, 15, 1'b1, 1'b1);
        end
        solo(4'(2), 1'b1, 4'(2), 1'b1, 1'b0, 4'(0), 1);

        // R11: reset in mid-run clears counters and masks
        req = "R11";
        solo(4'(0), 1'b0, 4'(0), 1'b0, 1'b1, 4'(4), 3);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        model_reset();
        compare_all();
        solo(4'(4), 1'b1, 4'(0), 1'b0, 1'b0, 4'(0), 1);

        // R10: long taken-transfer stream with hits saturates every busy counter
        req = "R10";
        for (int n = 0; n < 4200; n++) begin
            issue(1'b1, 4'(1), 1'b1, 4'(1), 1'b1, 1'b1, 4'(1), 1'b1, 1'b1, 15, 1'b1, 1'b1);
        end
        chk("taken_full", longint'(tkc_o), CMAX);
        chk("total_full", longint'(total_o), CMAX);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule